// File: doc/BRIEF.md
# Burst Address Counter Controller

This block produces the address that one memory port uses for its access in each clock cycle. At every rising clock edge it picks one of four operations from three active-low controls. It can clear the address to zero, load an address supplied from outside, keep the previous address, or advance the previous address by one for burst transfers. The chosen address is held in a register and stays on the output until the next edge. That address is also the base for the next hold or advance.

The controls work on their own, with no link to chip selection, byte lanes or transfer direction. For that reason none of those signals enters the block. A burst can therefore keep advancing through cycles in which the memory access itself is deselected.

The controls have a fixed priority: clear first, then load, then advance or hold. An advance past the top address wraps to zero. An asynchronous active-low system reset also forces the address register to zero.

Top module: `burst_addr_ctrl`

## Requirements
- R1: While `rst_n_i` is low, `addr_o` is 0 at once, with no clock edge needed.
- R2: If `clear_n_i` is low at a rising edge, `addr_o` becomes 0 after that edge, whatever `strobe_n_i`, `step_n_i` and `ext_addr_i` carry.
- R3: If `clear_n_i` is high and `strobe_n_i` is low at a rising edge, `addr_o` becomes `ext_addr_i` after that edge.
- R4: If `clear_n_i`, `strobe_n_i` and `step_n_i` are all high at a rising edge, `addr_o` keeps its value, and `ext_addr_i` has no effect.
- R5: If `clear_n_i` and `strobe_n_i` are high and `step_n_i` is low at a rising edge, `addr_o` becomes its previous value plus one.
- R6: An advance from the top address, 0x7FFF with the default 15-bit width, gives 0.
- R7: A low `strobe_n_i` wins over a low `step_n_i`: the external address is loaded and is not advanced.
- R8: Each new `addr_o` is the base for the next operation, so back-to-back advances count up one per edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Port clock; all operations take effect on its rising edge |
| rst_n_i | input | 1 | Asynchronous active-low system reset |
| ext_addr_i | input | 15 | External address to be loaded |
| strobe_n_i | input | 1 | Active-low load strobe for the external address |
| step_n_i | input | 1 | Active-low advance; when high, the address is held |
| clear_n_i | input | 1 | Active-low synchronous clear to address 0 |
| addr_o | output | 15 | Registered address used for the current access |

## Verification
The bench drives cases where two controls are low together. This checks the priority: a design that ranks advance above load would show the external address plus one. A design that lets clear lose to load would show the external address in place of zero. An advance chain runs across 0x7FFF. A design that saturates there, or carries into a sixteenth bit, would fail to show 0. Hold cycles change the external address bus, so a design that loads when the strobe is high would move the output. The reset is asserted between clock edges to catch a design whose reset is synchronous.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
    localparam int ADDR_W = 15;

    typedef enum logic [1:0] {
        OP_CLEAR = 2'd0,
        OP_LOAD  = 2'd1,
        OP_HOLD  = 2'd2,
        OP_STEP  = 2'd3
    } op_e;
endpackage

// File: rtl/burst_op_decode.sv
module burst_op_decode
    import burst_addr_pkg::*;
(
    input  logic clear_n_i,
    input  logic strobe_n_i,
    input  logic step_n_i,
    output op_e  op_o
);
    // Fixed priority: clear, then load, then advance/hold.
    always_comb begin
        if (!clear_n_i)       op_o = OP_CLEAR;
        else if (!strobe_n_i) op_o = OP_LOAD;
        else if (!step_n_i)   op_o = OP_STEP;
        else                  op_o = OP_HOLD;
    end
endmodule

// File: rtl/burst_addr_next.sv
module burst_addr_next
    import burst_addr_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  op_e           op_i,
    input  logic [AW-1:0] cur_i,
    input  logic [AW-1:0] ext_i,
    output logic [AW-1:0] nxt_o
);
    localparam logic [AW-1:0] ONE  = AW'(1);
    localparam logic [AW-1:0] ZERO = '0;

    always_comb begin
        unique case (op_i)
            OP_CLEAR: nxt_o = ZERO;
            OP_LOAD:  nxt_o = ext_i;
            OP_STEP:  nxt_o = cur_i + ONE;   // modulo 2**AW wrap
            OP_HOLD:  nxt_o = cur_i;
            default:  nxt_o = cur_i;
        endcase
    end
endmodule

// File: rtl/burst_addr_reg.sv
module burst_addr_reg #(
    parameter int AW = burst_addr_pkg::ADDR_W
) (
    input  logic          clk_i,
    input  logic          rst_n_i,
    input  logic [AW-1:0] d_i,
    output logic [AW-1:0] q_o
);
    logic [AW-1:0] q_r;

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) q_r <= '0;
        else          q_r <= d_i;
    end

    always_comb q_o = q_r;
endmodule

// File: rtl/burst_addr_ctrl.sv
module burst_addr_ctrl
    import burst_addr_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk_i,
    input  logic          rst_n_i,
    input  logic [AW-1:0] ext_addr_i,
    input  logic          strobe_n_i,
    input  logic          step_n_i,
    input  logic          clear_n_i,
    output logic [AW-1:0] addr_o
);
    op_e           op;
    logic [AW-1:0] cur_addr;
    logic [AW-1:0] nxt_addr;

    burst_op_decode u_dec (
        .clear_n_i  (clear_n_i),
        .strobe_n_i (strobe_n_i),
        .step_n_i   (step_n_i),
        .op_o       (op)
    );

    burst_addr_next #(.AW(AW)) u_next (
        .op_i  (op),
        .cur_i (cur_addr),
        .ext_i (ext_addr_i),
        .nxt_o (nxt_addr)
    );

    burst_addr_reg #(.AW(AW)) u_reg (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .d_i     (nxt_addr),
        .q_o     (cur_addr)
    );

    assign addr_o = cur_addr;
endmodule

// File: rtl/burst_addr_ctrl_chk.sv
module burst_addr_ctrl_chk #(
    parameter int AW = burst_addr_pkg::ADDR_W
) (
    input logic          clk_i,
    input logic          rst_n_i,
    input logic [AW-1:0] ext_addr_i,
    input logic          strobe_n_i,
    input logic          step_n_i,
    input logic          clear_n_i,
    input logic [AW-1:0] addr_o
);
    always @(negedge rst_n_i) begin
        #1;
        a_r1_async_zero: assert (addr_o == '0);
    end

    a_r2_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !clear_n_i |=> addr_o == '0);

    a_r3_load_ext: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (clear_n_i && !strobe_n_i) |=> addr_o == $past(ext_addr_i));

    a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (clear_n_i && strobe_n_i && step_n_i) |=> $stable(addr_o));

    // R5, R6 and R8: advance by one, modulo the width
    a_r5_step: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (clear_n_i && strobe_n_i && !step_n_i) |=> addr_o == AW'($past(addr_o) + AW'(1)));
endmodule

bind burst_addr_ctrl burst_addr_ctrl_chk #(.AW(AW)) u_chk (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n_i),
    .ext_addr_i (ext_addr_i),
    .strobe_n_i (strobe_n_i),
    .step_n_i   (step_n_i),
    .clear_n_i  (clear_n_i),
    .addr_o     (addr_o)
);

// File: tb/tb_burst_addr_ctrl.sv
module tb_burst_addr_ctrl;
    localparam int AW = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic          strobe_n = 1'b1;
    logic          step_n = 1'b1;
    logic          clear_n = 1'b1;
    logic [AW-1:0] addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    burst_addr_ctrl #(.AW(AW)) dut (
        .clk_i      (clk),
        .rst_n_i    (rst_n),
        .ext_addr_i (ext_addr),
        .strobe_n_i (strobe_n),
        .step_n_i   (step_n),
        .clear_n_i  (clear_n),
        .addr_o     (addr)
    );

    // Vector fields: {req[3:0], clear_n, strobe_n, step_n, ext[14:0], expected[14:0]}
    localparam int NV = 14;
    localparam logic [36:0] VEC [NV] = '{
        {4'd3, 3'b101, 15'h1234, 15'h1234},  // R3 load
        {4'd4, 3'b111, 15'h0555, 15'h1234},  // R4 hold, bus changes
        {4'd5, 3'b110, 15'h0000, 15'h1235},  // R5 advance
        {4'd8, 3'b110, 15'h7777, 15'h1236},  // R8 chained advance
        {4'd7, 3'b100, 15'h7FFE, 15'h7FFE},  // R7 load beats advance
        {4'd5, 3'b110, 15'h0001, 15'h7FFF},  // R5
        {4'd6, 3'b110, 15'h0002, 15'h0000},  // R6 wrap
        {4'd8, 3'b110, 15'h0003, 15'h0001},  // R8
        {4'd3, 3'b101, 15'h4321, 15'h4321},  // R3
        {4'd2, 3'b000, 15'h2222, 15'h0000},  // R2 clear over load+advance
        {4'd3, 3'b101, 15'h0ABC, 15'h0ABC},  // R3
        {4'd2, 3'b010, 15'h1111, 15'h0000},  // R2 clear over advance
        {4'd5, 3'b110, 15'h5555, 15'h0001},  // R5
        {4'd4, 3'b111, 15'h7FFF, 15'h0001}   // R4
    };

    task automatic check(input int req, input logic [AW-1:0] exp);
        checks++;
        if (addr !== exp) begin
            fails++;
            $display("FAIL R%0d: addr_o actual %h expected %h", req, addr, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end

    initial begin
        // R1: reset state
        #5;
        check(1, '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(1, '0);

        for (int i = 0; i < NV; i++) begin
            {clear_n, strobe_n, step_n} = VEC[i][32:30];
            ext_addr = VEC[i][29:15];
            @(posedge clk);
            @(negedge clk);
            check(int'(VEC[i][36:33]), VEC[i][14:0]);
        end

        // R1: asynchronous reset mid-cycle, no edge
        clear_n = 1'b1; strobe_n = 1'b0; step_n = 1'b1; ext_addr = 15'h3C3C;
        @(posedge clk); @(negedge clk);
        check(3, 15'h3C3C);
        strobe_n = 1'b1;
        #3 rst_n = 1'b0;
        #2 check(1, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // R6: wrap right after a load of the top address
        strobe_n = 1'b0; ext_addr = 15'h7FFF;
        @(posedge clk); @(negedge clk);
        check(3, 15'h7FFF);
        strobe_n = 1'b1; step_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check(6, 15'h0000);
        step_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check(4, 15'h0000);

        summary();
    end
endmodule